// File: doc/BRIEF.md
# Collective Gate Engine

This block carries out barrier, broadcast, reduce and all-reduce steps inside a node. It keeps each scalar on chip and never touches main memory. It holds a table of programmable gates, and each gate does one receive-combine-send step. A gate collects either one or two incoming scalar operands. It merges them with a single integer operation and then forwards the result. The result can go to a remote node over the send port, to another local gate in the same cycle, or to both. Chaining gates in this way builds a multi-step algorithm, such as recursive doubling, a ring or a tree. An algorithm that needs k rounds per node uses k gates.

Each gate belongs to one of several barrier channels, and the channels run independently of each other. Starting a channel arms every gate that it owns. The start also places the node's own contribution into a chosen gate. When a gate marked as final fires, its channel raises a completion flag and keeps the value in a per-channel result register. One channel is set aside for system use, and only a privileged start can launch it. Operands that arrive at a gate before it is armed are parked in that gate. A second early operand for the same gate is dropped and raises a sticky error flag.

Top module: `collgate_engine`

## Requirements
- R1: After a synchronous active-low reset, `tx_valid`, every `chan_done` bit and `err_flag` are 0.
- R2: A gate configured with `cfg_two`=0 needs one operand and with `cfg_two`=1 needs two. The gate fires only once it is armed by a start of its channel and holds that many operands. A configuration write clears the gate's operands and armed state.
- R3: Op codes (`cfg_op`): 0 barrier, 1 AND, 2 OR, 3 XOR, 4 MAX, 5 SUM. With two operands, barrier passes the first-arrived operand, MAX picks the larger as signed two's complement, and SUM wraps modulo 2^DATA_W. With one operand, every op passes it through. Within one cycle, arrivals are ordered start, then chained result, then receive.
- R4: When a gate with `cfg_dest_en`=1 fires, `tx_valid` is 1 for one cycle on the clock edge after the edge that completed it. In that cycle `tx_node`, `tx_gate` and `tx_data` carry the configured destination node, the destination gate and the result.
- R5: When a gate with `cfg_next_en`=1 fires, its result is placed as an operand in gate `cfg_next_gate` on the same edge that loads the send port.
- R6: When a gate with `cfg_last`=1 fires, `chan_done[channel]` goes to 1 on that same edge, and `rd_data` shows the result while `rd_chan` selects that channel. An accepted start of a channel clears its `chan_done` bit on the start edge.
- R7: An operand that arrives at an unarmed gate is held and is used once the gate arms. A second operand to the same unarmed gate is dropped and sets `err_flag`, which stays at 1 until reset.
- R8: A start of channel SYS_CHAN (0 by default) with `start_priv`=0 has no effect: it arms nothing, deposits nothing and clears no flag.
- R9: At most one gate fires per cycle. When several gates are ready, the one with the lowest index fires first and the others fire in the following cycles.
- R10: Channels progress independently. Completing one channel neither fires nor marks done the gates of another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write the gate configuration below |
| cfg_gate | input | GIDX_W | Gate being configured |
| cfg_chan | input | CH_W | Owning channel |
| cfg_op | input | 3 | Operation code |
| cfg_two | input | 1 | 1: two operands, 0: one |
| cfg_dest_en | input | 1 | Send result to a remote node |
| cfg_dest_node | input | NODE_W | Destination node |
| cfg_dest_gate | input | GIDX_W | Gate at the destination |
| cfg_next_en | input | 1 | Chain result to a local gate |
| cfg_next_gate | input | GIDX_W | Local gate to chain to |
| cfg_last | input | 1 | Gate ends its channel |
| start_valid | input | 1 | Start a channel |
| start_priv | input | 1 | Privileged start |
| start_chan | input | CH_W | Channel to start |
| start_gate | input | GIDX_W | Gate receiving the local contribution |
| start_data | input | DATA_W | Local contribution |
| rx_valid | input | 1 | Incoming scalar |
| rx_gate | input | GIDX_W | Target gate of incoming scalar |
| rx_data | input | DATA_W | Incoming scalar value |
| tx_valid | output | 1 | Outgoing scalar |
| tx_node | output | NODE_W | Destination node |
| tx_gate | output | GIDX_W | Gate at destination |
| tx_data | output | DATA_W | Outgoing scalar value |
| chan_done | output | NUM_CHANNELS | Per-channel completion flags |
| rd_chan | input | CH_W | Channel whose result is shown |
| rd_data | output | DATA_W | Result register of `rd_chan` |
| err_flag | output | 1 | Sticky early-arrival error |

## Verification
The hardest case to reach from the ports is two gates becoming ready on the same edge. That case exercises the fire priority. The bench sets it up by parking early operands in two gates of an idle channel and then starting that channel, so that both gates complete on the start edge. It then checks that the two results leave on consecutive cycles, lower index first. A second hard case is the dropped second early operand. The bench exposes it by starting the channel afterwards: the sent result contains the first parked value and not the second. The operation sweep crosses every op code with a grid of 8-bit operands that includes the sign boundary.

// File: rtl/collgate_pkg.sv
// Shared types of the collective gate engine.
package collgate_pkg;
    // Combine operations applied by a gate.
    typedef enum logic [2:0] {
        OP_BAR = 3'd0,
        OP_AND = 3'd1,
        OP_OR  = 3'd2,
        OP_XOR = 3'd3,
        OP_MAX = 3'd4,
        OP_SUM = 3'd5
    } op_e;
endpackage

// File: rtl/collgate_alu.sv
// Combines the operands of the firing gate.
// Assumes a is the first-arrived operand; with one operand, a passes through.
module collgate_alu
    import collgate_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  op_e               op,
    input  logic              two,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    // Select the operation result.
    always_comb begin
        y = a;
        if (two) begin
            case (op)
                OP_AND:  y = a & b;
                OP_OR:   y = a | b;
                OP_XOR:  y = a ^ b;
                OP_MAX:  y = ($signed(a) >= $signed(b)) ? a : b;
                OP_SUM:  y = a + b;
                default: y = a;
            endcase
        end
    end
endmodule

// File: rtl/collgate_pick.sv
// Lowest-index-first selector of ready gates.
// Assumes N is a power of two so that idx covers every gate.
module collgate_pick #(
    parameter int N     = 64,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     gnt,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so that the lowest set index wins.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
        gnt = '0;
        if (any) gnt[idx] = 1'b1;
    end
endmodule

// File: rtl/collgate_slot.sv
// One gate: configuration, armed state and up to two operand slots.
// Assumes at most one start, one chained result and one receive per cycle.
// These are ordered start, chain, receive when they hit the same gate.
module collgate_slot
    import collgate_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CH_W   = 3,
    parameter int GIDX_W = 6,
    parameter int NODE_W = 10,
    parameter int MY_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [GIDX_W-1:0] cfg_gate,
    input  logic [CH_W-1:0]   cfg_chan,
    input  logic [2:0]        cfg_op,
    input  logic              cfg_two,
    input  logic              cfg_dest_en,
    input  logic [NODE_W-1:0] cfg_dest_node,
    input  logic [GIDX_W-1:0] cfg_dest_gate,
    input  logic              cfg_next_en,
    input  logic [GIDX_W-1:0] cfg_next_gate,
    input  logic              cfg_last,
    input  logic              start_ok,
    input  logic [CH_W-1:0]   start_chan,
    input  logic [GIDX_W-1:0] start_gate,
    input  logic [DATA_W-1:0] start_data,
    input  logic              chain_v,
    input  logic [GIDX_W-1:0] chain_gate,
    input  logic [DATA_W-1:0] chain_data,
    input  logic              rx_v,
    input  logic [GIDX_W-1:0] rx_gate,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              fire,
    output logic              ready,
    output logic [DATA_W-1:0] op0,
    output logic [DATA_W-1:0] op1,
    output logic [CH_W-1:0]   chan_o,
    output op_e               op_o,
    output logic              two_o,
    output logic              dest_en_o,
    output logic [NODE_W-1:0] dest_node_o,
    output logic [GIDX_W-1:0] dest_gate_o,
    output logic              next_en_o,
    output logic [GIDX_W-1:0] next_gate_o,
    output logic              last_o,
    output logic              err_o
);
    localparam logic [GIDX_W-1:0] ME = GIDX_W'(MY_IDX);

    logic              armed_q;
    logic [1:0]        have_q;
    logic [DATA_W-1:0] s0_q, s1_q;
    logic [1:0]        need;
    logic              cfg_hit, arm, armed_nx;
    logic [1:0]        have_n, limit;
    logic [DATA_W-1:0] s0_n, s1_n;
    logic              err_c;
    logic [2:0]        hit;
    logic [DATA_W-1:0] dat [3];

    assign cfg_hit = cfg_wr && (cfg_gate == ME);
    assign need    = two_o ? 2'd2 : 2'd1;
    assign arm     = start_ok && (start_chan == chan_o);
    assign armed_nx = (armed_q && !fire) || arm;
    assign limit   = armed_nx ? need : 2'd1;

    // Arrival sources in priority order.
    always_comb begin
        hit[0] = start_ok && (start_gate == ME);
        hit[1] = chain_v  && (chain_gate == ME);
        hit[2] = rx_v     && (rx_gate == ME);
        dat[0] = start_data;
        dat[1] = chain_data;
        dat[2] = rx_data;
    end

    // Fill operand slots in arrival order and flag overflow.
    always_comb begin
        s0_n   = s0_q;
        s1_n   = s1_q;
        have_n = fire ? 2'd0 : have_q;
        err_c  = 1'b0;
        for (int k = 0; k < 3; k++) begin
            if (hit[k]) begin
                if (have_n < limit) begin
                    if (have_n == 2'd0) s0_n = dat[k];
                    else                s1_n = dat[k];
                    have_n = have_n + 2'd1;
                end else begin
                    err_c = 1'b1;
                end
            end
        end
    end

    // Configuration and operand state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_o      <= '0;
            op_o        <= OP_BAR;
            two_o       <= 1'b0;
            dest_en_o   <= 1'b0;
            dest_node_o <= '0;
            dest_gate_o <= '0;
            next_en_o   <= 1'b0;
            next_gate_o <= '0;
            last_o      <= 1'b0;
            armed_q     <= 1'b0;
            have_q      <= 2'd0;
            s0_q        <= '0;
            s1_q        <= '0;
        end else if (cfg_hit) begin
            chan_o      <= cfg_chan;
            op_o        <= op_e'(cfg_op);
            two_o       <= cfg_two;
            dest_en_o   <= cfg_dest_en;
            dest_node_o <= cfg_dest_node;
            dest_gate_o <= cfg_dest_gate;
            next_en_o   <= cfg_next_en;
            next_gate_o <= cfg_next_gate;
            last_o      <= cfg_last;
            armed_q     <= 1'b0;
            have_q      <= 2'd0;
        end else begin
            armed_q <= armed_nx;
            have_q  <= have_n;
            s0_q    <= s0_n;
            s1_q    <= s1_n;
        end
    end

    assign ready = armed_q && (have_q == need);
    assign op0   = s0_q;
    assign op1   = s1_q;
    assign err_o = err_c && !cfg_hit;

    p_armed_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (have_q <= need));
    p_early_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |-> (have_q <= 2'd1));
    p_fire_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (armed_q && have_q == need));
endmodule

// File: rtl/collgate_engine.sv
// Collective gate engine top: gate table, fire selection, combine, send, chain.
// It also keeps the per-channel completion flags and results.
// Assumes NUM_GATES and NUM_CHANNELS are powers of two.
// Assumes a gate does not chain to itself.
module collgate_engine
    import collgate_pkg::*;
#(
    parameter int NUM_GATES    = 64,
    parameter int NUM_CHANNELS = 8,
    parameter int DATA_W       = 64,
    parameter int NODE_W       = 10,
    parameter int SYS_CHAN     = 0,
    localparam int GIDX_W = $clog2(NUM_GATES),
    localparam int CH_W   = $clog2(NUM_CHANNELS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wr,
    input  logic [GIDX_W-1:0]       cfg_gate,
    input  logic [CH_W-1:0]         cfg_chan,
    input  logic [2:0]              cfg_op,
    input  logic                    cfg_two,
    input  logic                    cfg_dest_en,
    input  logic [NODE_W-1:0]       cfg_dest_node,
    input  logic [GIDX_W-1:0]       cfg_dest_gate,
    input  logic                    cfg_next_en,
    input  logic [GIDX_W-1:0]       cfg_next_gate,
    input  logic                    cfg_last,
    input  logic                    start_valid,
    input  logic                    start_priv,
    input  logic [CH_W-1:0]         start_chan,
    input  logic [GIDX_W-1:0]       start_gate,
    input  logic [DATA_W-1:0]       start_data,
    input  logic                    rx_valid,
    input  logic [GIDX_W-1:0]       rx_gate,
    input  logic [DATA_W-1:0]       rx_data,
    output logic                    tx_valid,
    output logic [NODE_W-1:0]       tx_node,
    output logic [GIDX_W-1:0]       tx_gate,
    output logic [DATA_W-1:0]       tx_data,
    output logic [NUM_CHANNELS-1:0] chan_done,
    input  logic [CH_W-1:0]         rd_chan,
    output logic [DATA_W-1:0]       rd_data,
    output logic                    err_flag
);
    localparam logic [CH_W-1:0] SYS = CH_W'(SYS_CHAN);

    logic                 start_ok;
    logic [NUM_GATES-1:0] ready_vec, fire_vec, err_vec;
    logic                 fire_any;
    logic [GIDX_W-1:0]    fire_idx;
    logic [DATA_W-1:0]    op0_a [NUM_GATES];
    logic [DATA_W-1:0]    op1_a [NUM_GATES];
    logic [CH_W-1:0]      chan_a [NUM_GATES];
    op_e                  op_a [NUM_GATES];
    logic [NUM_GATES-1:0] two_a, dest_en_a, next_en_a, last_a;
    logic [NODE_W-1:0]    dest_node_a [NUM_GATES];
    logic [GIDX_W-1:0]    dest_gate_a [NUM_GATES];
    logic [GIDX_W-1:0]    next_gate_a [NUM_GATES];
    logic [DATA_W-1:0]    alu_y;
    logic                 chain_v;
    logic [GIDX_W-1:0]    chain_gate;
    logic                 fire_last;
    logic [CH_W-1:0]      fire_chan;
    logic [DATA_W-1:0]    res_q [NUM_CHANNELS];

    // The system channel only starts on a privileged request.
    assign start_ok = start_valid && ((start_chan != SYS) || start_priv);

    // One state slot per gate.
    for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
        collgate_slot #(
            .DATA_W(DATA_W), .CH_W(CH_W), .GIDX_W(GIDX_W),
            .NODE_W(NODE_W), .MY_IDX(g)
        ) u_slot (
            .clk(clk), .rst_n(rst_n),
            .cfg_wr(cfg_wr), .cfg_gate(cfg_gate), .cfg_chan(cfg_chan),
            .cfg_op(cfg_op), .cfg_two(cfg_two), .cfg_dest_en(cfg_dest_en),
            .cfg_dest_node(cfg_dest_node), .cfg_dest_gate(cfg_dest_gate),
            .cfg_next_en(cfg_next_en), .cfg_next_gate(cfg_next_gate),
            .cfg_last(cfg_last),
            .start_ok(start_ok), .start_chan(start_chan),
            .start_gate(start_gate), .start_data(start_data),
            .chain_v(chain_v), .chain_gate(chain_gate), .chain_data(alu_y),
            .rx_v(rx_valid), .rx_gate(rx_gate), .rx_data(rx_data),
            .fire(fire_vec[g]),
            .ready(ready_vec[g]), .op0(op0_a[g]), .op1(op1_a[g]),
            .chan_o(chan_a[g]), .op_o(op_a[g]), .two_o(two_a[g]),
            .dest_en_o(dest_en_a[g]), .dest_node_o(dest_node_a[g]),
            .dest_gate_o(dest_gate_a[g]), .next_en_o(next_en_a[g]),
            .next_gate_o(next_gate_a[g]), .last_o(last_a[g]),
            .err_o(err_vec[g])
        );
    end

    collgate_pick #(.N(NUM_GATES)) u_pick (
        .req(ready_vec), .gnt(fire_vec), .any(fire_any), .idx(fire_idx)
    );

    collgate_alu #(.DATA_W(DATA_W)) u_alu (
        .op(op_a[fire_idx]), .two(two_a[fire_idx]),
        .a(op0_a[fire_idx]), .b(op1_a[fire_idx]), .y(alu_y)
    );

    assign chain_v    = fire_any && next_en_a[fire_idx];
    assign chain_gate = next_gate_a[fire_idx];
    assign fire_last  = fire_any && last_a[fire_idx];
    assign fire_chan  = chan_a[fire_idx];

    // Send port register: one pulse per firing gate with a destination.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_node  <= '0;
            tx_gate  <= '0;
            tx_data  <= '0;
        end else begin
            tx_valid <= fire_any && dest_en_a[fire_idx];
            if (fire_any) begin
                tx_node <= dest_node_a[fire_idx];
                tx_gate <= dest_gate_a[fire_idx];
                tx_data <= alu_y;
            end
        end
    end

    // Completion flags and result registers per channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_done <= '0;
            for (int c = 0; c < NUM_CHANNELS; c++) res_q[c] <= '0;
        end else begin
            for (int c = 0; c < NUM_CHANNELS; c++) begin
                if (start_ok && start_chan == CH_W'(c)) chan_done[c] <= 1'b0;
                if (fire_last && fire_chan == CH_W'(c)) begin
                    chan_done[c] <= 1'b1;
                    res_q[c]     <= alu_y;
                end
            end
        end
    end

    // Sticky error on any dropped operand.
    always_ff @(posedge clk) begin
        if (!rst_n) err_flag <= 1'b0;
        else if (|err_vec) err_flag <= 1'b1;
    end

    assign rd_data = res_q[rd_chan];

    p_one_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fire_vec));
    p_tx_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_any && dest_en_a[fire_idx]) |=> tx_valid);
    p_done_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_last && !start_ok) |=> chan_done[$past(fire_chan)]);
    p_sys_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_valid && !start_priv && start_chan == SYS) |=> !$fell(chan_done[SYS_CHAN]));
endmodule

// File: tb/collgate_engine_bench.sv
module collgate_engine_bench;
    localparam int NG = 8, NC = 4, DW = 8, NW = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_wr = 0, cfg_two = 0, cfg_dest_en = 0, cfg_next_en = 0, cfg_last = 0;
    logic [2:0] cfg_gate = 0, cfg_dest_gate = 0, cfg_next_gate = 0, cfg_op = 0;
    logic [1:0] cfg_chan = 0, start_chan = 0, rd_chan = 0;
    logic [NW-1:0] cfg_dest_node = 0;
    logic start_valid = 0, start_priv = 0, rx_valid = 0;
    logic [2:0] start_gate = 0, rx_gate = 0;
    logic [DW-1:0] start_data = 0, rx_data = 0;
    logic tx_valid, err_flag;
    logic [NW-1:0] tx_node;
    logic [2:0] tx_gate;
    logic [DW-1:0] tx_data, rd_data;
    logic [NC-1:0] chan_done;
    int vectors = 0, fails = 0, cycles = 0;
    logic [7:0] vals [10] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF,
                              8'h55, 8'hAA, 8'h0F, 8'hF0, 8'h3C};

    collgate_engine #(.NUM_GATES(NG), .NUM_CHANNELS(NC), .DATA_W(DW),
                      .NODE_W(NW), .SYS_CHAN(0)) u_collgate_engine (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_gate(cfg_gate),
        .cfg_chan(cfg_chan), .cfg_op(cfg_op), .cfg_two(cfg_two),
        .cfg_dest_en(cfg_dest_en), .cfg_dest_node(cfg_dest_node),
        .cfg_dest_gate(cfg_dest_gate), .cfg_next_en(cfg_next_en),
        .cfg_next_gate(cfg_next_gate), .cfg_last(cfg_last),
        .start_valid(start_valid), .start_priv(start_priv),
        .start_chan(start_chan), .start_gate(start_gate),
        .start_data(start_data), .rx_valid(rx_valid), .rx_gate(rx_gate),
        .rx_data(rx_data), .tx_valid(tx_valid), .tx_node(tx_node),
        .tx_gate(tx_gate), .tx_data(tx_data), .chan_done(chan_done),
        .rd_chan(rd_chan), .rd_data(rd_data), .err_flag(err_flag)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [2:0] g, input logic [1:0] ch, input logic [2:0] op,
                       input logic two, input logic de, input logic [NW-1:0] dn,
                       input logic [2:0] dg, input logic ne, input logic [2:0] ng,
                       input logic last);
        @(negedge clk);
        cfg_wr = 1; cfg_gate = g; cfg_chan = ch; cfg_op = op; cfg_two = two;
        cfg_dest_en = de; cfg_dest_node = dn; cfg_dest_gate = dg;
        cfg_next_en = ne; cfg_next_gate = ng; cfg_last = last;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic do_start(input logic [1:0] ch, input logic priv,
                            input logic [2:0] g, input logic [DW-1:0] d);
        @(negedge clk);
        start_valid = 1; start_chan = ch; start_priv = priv; start_gate = g; start_data = d;
        @(negedge clk);
        start_valid = 0; start_priv = 0;
    endtask

    task automatic do_rx(input logic [2:0] g, input logic [DW-1:0] d);
        @(negedge clk);
        rx_valid = 1; rx_gate = g; rx_data = d;
        @(negedge clk);
        rx_valid = 0;
    endtask

    // Reference combine per R3, computed from integer arithmetic.
    function automatic logic [7:0] ref_op(input int op, input int a, input int b);
        int sa, sb;
        sa = (a >= 128) ? a - 256 : a;
        sb = (b >= 128) ? b - 256 : b;
        case (op)
            1: return 8'(a & b);
            2: return 8'(a | b);
            3: return 8'(a ^ b);
            4: return (sa >= sb) ? 8'(a) : 8'(b);
            5: return 8'((a + b) % 256);
            default: return 8'(a);
        endcase
    endfunction

    // Watchdog.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                $display("FAIL watchdog expired");
                $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 tx_valid after reset", 64'(tx_valid), 0);
        check("R1 chan_done after reset", 64'(chan_done), 0);
        check("R1 err_flag after reset", 64'(err_flag), 0);

        // R3/R4/R6 sweep: every op code against a grid of operands.
        rd_chan = 1;
        for (int op = 0; op < 6; op++) begin
            cfg(3'd1, 2'd1, 3'(op), 1'b1, 1'b1, 4'd5, 3'd3, 1'b0, 3'd0, 1'b1);
            for (int i = 0; i < 10; i++) begin
                for (int j = 0; j < 10; j++) begin
                    do_start(2'd1, 1'b0, 3'd1, vals[i]);
                    if (i == 0 && j == 0)
                        check("R6 done cleared by start", 64'(chan_done[1]), 0);
                    if (i == 0 && j == 0)
                        check("R2 no fire on one of two operands", 64'(tx_valid), 0);
                    do_rx(3'd1, vals[j]);
                    @(negedge clk);
                    check("R3 op result", 64'(tx_data), 64'(ref_op(op, int'(vals[i]), int'(vals[j]))));
                    if (i == 9 && j == 9) begin
                        check("R4 tx_valid pulse", 64'(tx_valid), 1);
                        check("R4 tx_node", 64'(tx_node), 5);
                        check("R4 tx_gate", 64'(tx_gate), 3);
                        check("R6 done set", 64'(chan_done[1]), 1);
                        check("R6 result register", 64'(rd_data),
                              64'(ref_op(op, int'(vals[i]), int'(vals[j]))));
                        @(negedge clk);
                        check("R4 single-cycle pulse", 64'(tx_valid), 0);
                    end
                end
            end
        end

        // R2: single-operand gate passes the start contribution.
        cfg(3'd2, 2'd2, 3'd5, 1'b0, 1'b1, 4'd7, 3'd0, 1'b0, 3'd0, 1'b0);
        do_start(2'd2, 1'b0, 3'd2, 8'h33);
        @(negedge clk);
        check("R2 one-operand fire valid", 64'(tx_valid), 1);
        check("R2 one-operand data", 64'(tx_data), 64'h33);

        // R5: two-step chain on channel 3.
        rd_chan = 3;
        cfg(3'd4, 2'd3, 3'd5, 1'b1, 1'b1, 4'd1, 3'd4, 1'b1, 3'd5, 1'b0);
        cfg(3'd5, 2'd3, 3'd5, 1'b1, 1'b1, 4'd2, 3'd5, 1'b0, 3'd0, 1'b1);
        do_start(2'd3, 1'b0, 3'd4, 8'd10);
        do_rx(3'd4, 8'd20);
        @(negedge clk);
        check("R5 first step data", 64'(tx_data), 30);
        check("R5 first step node", 64'(tx_node), 1);
        do_rx(3'd5, 8'd5);
        @(negedge clk);
        check("R5 chained step data", 64'(tx_data), 35);
        check("R5 chained step valid", 64'(tx_valid), 1);
        check("R6 chain done", 64'(chan_done[3]), 1);
        check("R6 chain result", 64'(rd_data), 35);

        // R7: early operand held until the gate arms.
        cfg(3'd2, 2'd2, 3'd3, 1'b1, 1'b1, 4'd8, 3'd0, 1'b0, 3'd0, 1'b0);
        do_rx(3'd2, 8'h0F);
        @(negedge clk);
        check("R7 no fire while unarmed", 64'(tx_valid), 0);
        do_start(2'd2, 1'b0, 3'd2, 8'hF0);
        @(negedge clk);
        check("R7 held operand used", 64'(tx_data), 64'hFF);
        check("R7 no error on single early", 64'(err_flag), 0);

        // R9: two gates ready on the same edge, lowest index first.
        cfg(3'd6, 2'd2, 3'd5, 1'b1, 1'b1, 4'd6, 3'd0, 1'b0, 3'd0, 1'b0);
        cfg(3'd7, 2'd2, 3'd5, 1'b0, 1'b1, 4'd7, 3'd0, 1'b0, 3'd0, 1'b0);
        do_rx(3'd6, 8'h11);
        do_rx(3'd7, 8'h22);
        do_start(2'd2, 1'b0, 3'd6, 8'h01);
        @(negedge clk);
        check("R9 first fire node", 64'(tx_node), 6);
        check("R9 first fire data", 64'(tx_data), 64'h12);
        @(negedge clk);
        check("R9 second fire valid", 64'(tx_valid), 1);
        check("R9 second fire node", 64'(tx_node), 7);
        check("R9 second fire data", 64'(tx_data), 64'h22);

        // R8: unprivileged start of the system channel is ignored.
        rd_chan = 0;
        cfg(3'd1, 2'd0, 3'd5, 1'b0, 1'b1, 4'd9, 3'd0, 1'b0, 3'd0, 1'b1);
        do_start(2'd0, 1'b0, 3'd1, 8'h44);
        @(negedge clk);
        check("R8 rejected start no tx", 64'(tx_valid), 0);
        check("R8 rejected start no done", 64'(chan_done[0]), 0);
        do_start(2'd0, 1'b1, 3'd1, 8'h44);
        @(negedge clk);
        check("R8 privileged start data", 64'(tx_data), 64'h44);
        check("R8 privileged start valid", 64'(tx_valid), 1);
        check("R8 privileged start done", 64'(chan_done[0]), 1);

        // R10: channels 1 and 3 in flight together.
        cfg(3'd0, 2'd1, 3'd1, 1'b1, 1'b1, 4'd1, 3'd0, 1'b0, 3'd0, 1'b1);
        cfg(3'd4, 2'd3, 3'd2, 1'b1, 1'b1, 4'd3, 3'd0, 1'b0, 3'd0, 1'b1);
        do_start(2'd1, 1'b0, 3'd0, 8'hF3);
        do_start(2'd3, 1'b0, 3'd4, 8'h0C);
        do_rx(3'd4, 8'h30);
        @(negedge clk);
        check("R10 channel 3 data", 64'(tx_data), 64'h3C);
        check("R10 channel 3 done", 64'(chan_done[3]), 1);
        check("R10 channel 1 still open", 64'(chan_done[1]), 0);
        do_rx(3'd0, 8'h3F);
        @(negedge clk);
        check("R10 channel 1 data", 64'(tx_data), 64'h33);
        check("R10 channel 1 done", 64'(chan_done[1]), 1);

        // R7: second early operand is dropped and flags an error.
        cfg(3'd3, 2'd1, 3'd5, 1'b1, 1'b1, 4'd4, 3'd0, 1'b0, 3'd0, 1'b0);
        do_rx(3'd3, 8'd3);
        do_rx(3'd3, 8'd100);
        @(negedge clk);
        check("R7 error on second early", 64'(err_flag), 1);
        do_start(2'd1, 1'b0, 3'd3, 8'd4);
        @(negedge clk);
        check("R7 dropped operand excluded", 64'(tx_data), 7);
        check("R7 error sticky", 64'(err_flag), 1);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule